// File: doc/BRIEF.md
# Touchscreen ADC SPI Responder

This block is an SPI slave (mode 0, MSB first) that stands in for a resistive touchscreen converter. It does no analog conversion. It takes a pen-down flag and the pen position in screen pixels, and turns them into the raw 12-bit codes that a real converter would report. The host sends a control byte that names a channel. The 12-bit result then comes back over MISO in the two bytes the host clocks next.

The X and Y codes follow a fixed linear map from pixels to converter counts. The screen size is set by parameters, and the division is by a constant. The remaining channels (battery, both pressure inputs, auxiliary/microphone and one temperature input) report zero. Selecting the other temperature channel latches the pen state onto an active-low status output. Releasing chip select ends the session and forgets the channel.

The SPI pins are synchronised into the system clock domain. The serial clock must therefore run at well under a quarter of the system clock rate.

Top module: `tsc_adc_resp`

## Requirements
- R1: A received byte with bit 7 set is a control byte, and bits 6..4 of it are the channel: 5 is X, 1 is Y, 0 is the pen-status temperature channel, and 2, 3, 4, 6 and 7 are the zero channels. A byte with bit 7 clear is never taken as a control byte.
- R2: The X channel code is x*0xDD0/SCREEN_W + 0x100 with the pen down and 0 with the pen up. The quotient is truncated and the result is limited to 0xFFF.
- R3: The Y channel code is y*0xE70/SCREEN_H + 0x0B0 with the pen down and 0xFFF with the pen up. The quotient is truncated and the result is limited to 0xFFF, which includes y values at or beyond SCREEN_H.
- R4: In the byte that follows a control byte, MISO carries {1'b0, code[11:5]}.
- R5: In the byte after that, MISO carries {code[4:0], 3'b000}. Every later byte is 0x00 until a new control byte arrives.
- R6: Channels 0, 2, 3, 4, 6 and 7 produce a code of 0, so both of their response bytes are 0x00.
- R7: pen_n_o is 1 after reset. A control byte for channel 0 sets it to the inverse of pen_down_i, sampled when that byte completes. Control bytes for any other channel leave it unchanged.
- R8: Raising cs_ni clears the pending response and the sequence position. Until a control byte is received in a frame, every response byte is 0x00. A control byte that arrives mid-sequence restarts the sequence with its own code.
- R9: MOSI is sampled on rising SCLK and MISO changes only after falling SCLK. There are 8 bits per byte, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock from host |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host |
| pen_down_i | input | 1 | Pen is touching the screen |
| pen_x_i | input | $clog2(SCREEN_W) | Pen X position in pixels |
| pen_y_i | input | $clog2(SCREEN_H) | Pen Y position in pixels |
| pen_n_o | output | 1 | Latched pen status, 0 when touched |

## Verification
Each SPI pin passes through two synchroniser stages and an edge register, so a falling SCLK shows up on MISO about three to four system clocks later. The bench holds each SCLK level for eight system clocks and reads MISO just before it raises SCLK. That way every MISO bit is sampled after its update is due. The response to a control byte is due in the next byte and the one after it, so the bench compares the second, third and fourth bytes of each frame. pen_n_o is settled about four clocks after the eighth rising edge of the control byte, and the bench reads it only after the frame has closed.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 12;
  localparam int CHAN_W = 3;

  localparam logic [CHAN_W-1:0] CH_STATUS = 3'd0;
  localparam logic [CHAN_W-1:0] CH_Y      = 3'd1;
  localparam logic [CHAN_W-1:0] CH_X      = 3'd5;

  localparam int X_SPAN = 'hDD0;
  localparam int X_BASE = 'h100;
  localparam int Y_SPAN = 'hE70;
  localparam int Y_BASE = 'h0B0;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_LOW  = 2'd1,
    RSP_DONE = 2'd2
  } rsp_ph_e;
endpackage

// File: rtl/tsc_spi_shifter.sv
module tsc_spi_shifter
  import tsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              miso_o,
  output logic              cs_idle_o,
  output logic              sclk_fall_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  // bit 2: cs, bit 1: sclk, bit 0: mosi
  logic [2:0] sync_q [SYNC_STAGES];
  logic       sclk_prev_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic cs_s, sclk_s, mosi_s, rise;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 3'b100;
      else if (g == 0) sync_q[g] <= {cs_ni, sclk_i, mosi_i};
      else sync_q[g] <= sync_q[g-1];
    end
  end

  assign cs_s   = sync_q[SYNC_STAGES-1][2];
  assign sclk_s = sync_q[SYNC_STAGES-1][1];
  assign mosi_s = sync_q[SYNC_STAGES-1][0];

  assign rise        = sclk_s && !sclk_prev_q && !cs_s;
  assign sclk_fall_o = !sclk_s && sclk_prev_q && !cs_s;
  assign cs_idle_o   = cs_s;
  assign byte_done_o = rise && (bit_cnt_q == LAST_BIT);
  assign rx_byte_o   = {rx_q[BYTE_W-2:0], mosi_s};
  assign miso_o      = tx_q[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      bit_cnt_q   <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      if (cs_s) begin
        bit_cnt_q <= '0;
        tx_q      <= '0;
      end else begin
        if (rise) begin
          rx_q      <= rx_byte_o;
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        if (sclk_fall_o) begin
          // first fall of a byte presents the new response MSB
          if (bit_cnt_q == '0) tx_q <= tx_byte_i;
          else tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/tsc_code_gen.sv
module tsc_code_gen
  import tsc_pkg::*;
#(
  parameter int SCREEN_W = 256,
  parameter int SCREEN_H = 192,
  localparam int XW = $clog2(SCREEN_W),
  localparam int YW = $clog2(SCREEN_H)
) (
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              pen_down_i,
  input  logic [XW-1:0]     pen_x_i,
  input  logic [YW-1:0]     pen_y_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int XPW = XW + CODE_W + 1;
  localparam int YPW = YW + CODE_W + 1;

  logic [XPW-1:0] x_full;
  logic [YPW-1:0] y_full;
  logic [CODE_W-1:0] x_code, y_code;

  always_comb begin
    x_full = (XPW'(pen_x_i) * XPW'(X_SPAN)) / XPW'(SCREEN_W) + XPW'(X_BASE);
    y_full = (YPW'(pen_y_i) * YPW'(Y_SPAN)) / YPW'(SCREEN_H) + YPW'(Y_BASE);
    x_code = (x_full > XPW'(CODE_MAX)) ? CODE_MAX : x_full[CODE_W-1:0];
    y_code = (y_full > YPW'(CODE_MAX)) ? CODE_MAX : y_full[CODE_W-1:0];
    unique case (chan_i)
      CH_X:    code_o = pen_down_i ? x_code : '0;
      CH_Y:    code_o = pen_down_i ? y_code : CODE_MAX;
      default: code_o = '0;
    endcase
  end
endmodule

// File: rtl/tsc_resp_seq.sv
module tsc_resp_seq
  import tsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_idle_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              pen_down_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output rsp_ph_e           phase_o,
  output logic              pen_n_o
);
  localparam int LOW_W = CODE_W - (BYTE_W - 1);

  logic [CODE_W-1:0] code_q;
  logic is_ctrl;

  assign is_ctrl = rx_byte_i[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q    <= '0;
      tx_byte_o <= '0;
      phase_o   <= RSP_NONE;
      pen_n_o   <= 1'b1;
    end else if (cs_idle_i) begin
      tx_byte_o <= '0;
      phase_o   <= RSP_NONE;
    end else if (byte_done_i) begin
      if (is_ctrl) begin
        code_q    <= code_i;
        tx_byte_o <= {1'b0, code_i[CODE_W-1:LOW_W]};
        phase_o   <= RSP_LOW;
        if (rx_byte_i[BYTE_W-2 -: CHAN_W] == CH_STATUS) pen_n_o <= !pen_down_i;
      end else if (phase_o == RSP_LOW) begin
        tx_byte_o <= {code_q[LOW_W-1:0], {(BYTE_W-LOW_W){1'b0}}};
        phase_o   <= RSP_DONE;
      end else begin
        tx_byte_o <= '0;
      end
    end
  end
endmodule

// File: rtl/tsc_adc_resp.sv
module tsc_adc_resp
  import tsc_pkg::*;
#(
  parameter int SCREEN_W = 256,
  parameter int SCREEN_H = 192,
  parameter int SYNC_STAGES = 2,
  localparam int XW = $clog2(SCREEN_W),
  localparam int YW = $clog2(SCREEN_H)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          pen_down_i,
  input  logic [XW-1:0] pen_x_i,
  input  logic [YW-1:0] pen_y_i,
  output logic          pen_n_o
);
  logic              cs_idle, sclk_fall, byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [CODE_W-1:0] code;
  rsp_ph_e           phase;

  tsc_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .tx_byte_i   (tx_byte),
    .miso_o,
    .cs_idle_o   (cs_idle),
    .sclk_fall_o (sclk_fall),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte)
  );

  tsc_code_gen #(.SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H)) u_code (
    .chan_i     (rx_byte[BYTE_W-2 -: CHAN_W]),
    .pen_down_i,
    .pen_x_i,
    .pen_y_i,
    .code_o     (code)
  );

  tsc_resp_seq u_seq (
    .clk_i, .rst_ni,
    .cs_idle_i   (cs_idle),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .pen_down_i,
    .code_i      (code),
    .tx_byte_o   (tx_byte),
    .phase_o     (phase),
    .pen_n_o
  );
endmodule

// File: rtl/tsc_adc_resp_chk.sv
module tsc_adc_resp_chk
  import tsc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_done,
  input logic [BYTE_W-1:0] rx_byte,
  input logic [BYTE_W-1:0] tx_byte,
  input rsp_ph_e           phase,
  input logic              cs_idle,
  input logic              sclk_fall,
  input logic              miso,
  input logic              pen_n
);
  assert_hi_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && !cs_idle && rx_byte[7] |=> !tx_byte[7] && phase == RSP_LOW);

  assert_lo_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && !cs_idle && !rx_byte[7] && phase == RSP_LOW |=> tx_byte[2:0] == 3'b000 && phase == RSP_DONE);

  assert_tail_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && !cs_idle && !rx_byte[7] && phase != RSP_LOW |=> tx_byte == '0);

  assert_cs_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_idle |=> tx_byte == '0 && phase == RSP_NONE && !miso);

  assert_status_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pen_n) |-> $past(byte_done && rx_byte[7] && rx_byte[6:4] == CH_STATUS));

  assert_miso_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall && !cs_idle |=> $stable(miso));
endmodule

bind tsc_adc_resp tsc_adc_resp_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .byte_done (byte_done),
  .rx_byte   (rx_byte),
  .tx_byte   (tx_byte),
  .phase     (phase),
  .cs_idle   (cs_idle),
  .sclk_fall (sclk_fall),
  .miso      (miso_o),
  .pen_n     (pen_n_o)
);

// File: tb/sim_tsc_adc_resp.sv
`timescale 1ns/1ps
module sim_tsc_adc_resp;
  localparam int SW = 256;
  localparam int SH = 192;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, pen_down = 1'b0, pen_n;
  logic [7:0] px = '0, py = '0;
  int total = 0, bad = 0;
  bit model_pen_n = 1'b1;
  logic [7:0] rsp [4];

  always #5 clk = ~clk;

  tsc_adc_resp #(.SCREEN_W(SW), .SCREEN_H(SH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .pen_down_i(pen_down), .pen_x_i(px), .pen_y_i(py), .pen_n_o(pen_n)
  );

  function automatic int exp_code(int ch, bit pen, int x, int y);
    int v;
    case (ch)
      5: v = pen ? x * 3536 / SW + 256 : 0;
      1: v = pen ? y * 3696 / SH + 176 : 4095;
      default: v = 0;
    endcase
    return (v > 4095) ? 4095 : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3);
    logic [7:0] r;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer(b0, r); rsp[0] = r;
    xfer(b1, r); rsp[1] = r;
    xfer(b2, r); rsp[2] = r;
    xfer(b3, r); rsp[3] = r;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_chan(int ch, bit pen, int x, int y, logic [3:0] lo);
    int c;
    pen_down = pen; px = 8'(x); py = 8'(y);
    c = exp_code(ch, pen, x, y);
    frame({1'b1, 3'(ch), lo}, 8'h00, {1'b0, 7'($urandom)}, 8'h00);
    if (ch == 0) model_pen_n = !pen;
    chk("R8 first byte", int'(rsp[0]), 0);
    chk("R4 high byte", int'(rsp[1]), c >> 5);
    chk("R5 low byte", int'(rsp[2]), (c & 31) << 3);
    chk("R5 trailing", int'(rsp[3]), 0);
    chk("R7 pen status", int'(pen_n), int'(model_pen_n));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 reset pen_n", int'(pen_n), 1);
    chk("R8 reset miso", int'(miso), 0);

    // R8: no control byte, all zero; R1 bit7 clear bytes are not control
    frame(8'h55, 8'h7F, 8'h50, 8'h10);
    for (int i = 0; i < 4; i++) chk("R8 no control", int'(rsp[i]), 0);

    // R2 directed
    run_chan(5, 1, 255, 0, 4'h0);
    run_chan(5, 0, 200, 0, 4'h3);
    run_chan(5, 1, 0, 0, 4'hF);
    // R3 directed: pen up and saturation
    run_chan(1, 0, 0, 100, 4'h0);
    run_chan(1, 1, 0, 191, 4'h0);
    run_chan(1, 1, 0, 250, 4'h0);
    // R6 zero channels
    run_chan(2, 1, 10, 10, 4'h0);
    run_chan(6, 1, 10, 10, 4'h0);
    // R7: status channel, then other channel must not touch it
    run_chan(0, 1, 0, 0, 4'h0);
    run_chan(3, 0, 0, 0, 4'h0);
    chk("R7 held by non-status", int'(pen_n), 0);
    run_chan(0, 0, 0, 0, 4'h0);

    // R8 restart: control X then control Y
    pen_down = 1; px = 8'd100; py = 8'd60;
    frame({1'b1, 3'd5, 4'h0}, {1'b1, 3'd1, 4'h0}, 8'h00, 8'h00);
    chk("R8 restart high X", int'(rsp[1]), exp_code(5, 1, 100, 60) >> 5);
    chk("R8 restart high Y", int'(rsp[2]), exp_code(1, 1, 100, 60) >> 5);
    chk("R8 restart low Y", int'(rsp[3]), (exp_code(1, 1, 100, 60) & 31) << 3);

    // R8: chip select release mid-sequence clears
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer({1'b1, 3'd5, 4'h0}, rsp[0]);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    frame(8'h00, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 4; i++) chk("R8 cleared by cs", int'(rsp[i]), 0);

    // random mix covering R1..R9
    for (int n = 0; n < 40; n++)
      run_chan(int'($urandom % 8), bit'($urandom % 2), int'($urandom % 256),
               int'($urandom % 256), 4'($urandom));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule